// File: doc/BRIEF.md
# Sequential Shift-Add Fixed-Point Multiplier

This block multiplies two sign-magnitude fixed-point words over several clock cycles. It is meant for targets where a single-cycle combinational multiplier costs too much area or timing. Each operand is a WIDTH-bit word. The top bit holds the sign, and the remaining WIDTH-1 bits hold the magnitude. The lowest FRAC_W bits of the magnitude are the fraction.

A one-cycle `start` pulse captures both operands. The block then examines one multiplier magnitude bit per cycle. Whenever that bit is 1, it adds the multiplicand, shifted left to match the bit's position, into a double-width accumulator. After WIDTH-1 such steps it realigns the product to the operand format by dropping the FRAC_W lowest bits, then sets the sign and the overflow flag. The result is held on `result` with `done` high until the next accepted start.

Top module: `fxm_seq_mult`

## Requirements
- R1: After reset, `done`, `ovf` and `result` are all 0.
- R2: With the defaults FRAC_W=15 and WIDTH=32, bit 31 of an operand is its sign (1 = negative) and bits 30:0 are its magnitude. The result magnitude `result[30:0]` equals the full product of the operand magnitudes shifted right by FRAC_W, with the shifted-out bits truncated, and keeps the low WIDTH-1 bits.
- R3: `ovf` is 1 exactly when the full magnitude product has any bit set at position FRAC_W+WIDTH-1 or above; otherwise it is 0.
- R4: `result[WIDTH-1]` is the XOR of the two operand signs, except that it is 0 whenever `result[WIDTH-2:0]` is zero (this includes negative-zero operands and products that truncate to zero).
- R5: If `start` is sampled high at clock edge k while the block is idle or done, `done` is 0 after edges k through k+WIDTH-2 and becomes 1 after edge k+WIDTH-1.
- R6: Once `done` is 1, it stays 1 and `result` and `ovf` stay unchanged until a new `start` is sampled. That start clears `done` in the following cycle.
- R7: A `start` sampled while a multiplication is in progress is ignored. The running product and its completion cycle are unaffected.
- R8: The operands are sampled only on the edge that accepts `start`. Later changes on `op_a` or `op_b` do not affect the pending result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a multiplication when not busy |
| op_a | input | WIDTH | Multiplicand, sign-magnitude fixed point |
| op_b | input | WIDTH | Multiplier, sign-magnitude fixed point |
| result | output | WIDTH | Product, sign-magnitude fixed point |
| done | output | 1 | Result valid; held until next accepted start |
| ovf | output | 1 | Product magnitude exceeded WIDTH-1 bits |

## Verification
The assertions assume that `start` is a synchronous level sampled only on rising edges, and that the operand buses are stable around the edge that accepts it. They also assume nothing about `start` being a single-cycle pulse, except where the restart rule is checked. The stimulus drives every input on the falling edge, holds `start` for exactly one cycle per launch, and only changes the operands after the accepting edge has passed. The one deliberate exception is a second `start` raised in the middle of a run, which tests that it is ignored.

// File: rtl/fxm_pkg.sv
package fxm_pkg;
    typedef enum logic [1:0] {
        FXM_IDLE = 2'd0,
        FXM_RUN  = 2'd1,
        FXM_DONE = 2'd2
    } fxm_state_e;
endpackage

// File: rtl/fxm_split.sv
module fxm_split #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    output logic             sgn,
    output logic [WIDTH-2:0] mag
);
    always_comb begin
        sgn = word[WIDTH-1];
        mag = word[WIDTH-2:0];
    end
endmodule

// File: rtl/fxm_step.sv
module fxm_step #(
    parameter int MAG_W = 31,
    parameter int ACC_W = 62
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] mcand,
    input  logic [MAG_W-1:0] mplier,
    output logic [ACC_W-1:0] acc_nx,
    output logic [ACC_W-1:0] mcand_nx,
    output logic [MAG_W-1:0] mplier_nx
);
    // one partial product per call: add when the current multiplier bit is set
    always_comb begin
        acc_nx    = mplier[0] ? (acc + mcand) : acc;
        mcand_nx  = mcand << 1;
        mplier_nx = mplier >> 1;
    end
endmodule

// File: rtl/fxm_realign.sv
module fxm_realign #(
    parameter int FRAC_W = 15,
    parameter int MAG_W  = 31,
    parameter int ACC_W  = 62
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             sgn_in,
    output logic [MAG_W-1:0] mag,
    output logic             sgn,
    output logic             ovf
);
    logic [ACC_W-1:0] shifted;

    always_comb begin
        shifted = acc >> FRAC_W;
        mag     = shifted[MAG_W-1:0];
        ovf     = |shifted[ACC_W-1:MAG_W];
        sgn     = sgn_in & (|mag);
    end
endmodule

// File: rtl/fxm_seq_mult.sv
module fxm_seq_mult
    import fxm_pkg::*;
#(
    parameter int FRAC_W = 15,
    parameter int WIDTH  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] result,
    output logic             done,
    output logic             ovf
);
    localparam int MAG_W = WIDTH - 1;
    localparam int ACC_W = 2 * MAG_W;
    localparam int CNT_W = $clog2(MAG_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAG_W - 1);

    typedef struct packed {
        fxm_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] mcand;
        logic [MAG_W-1:0] mplier;
        logic             sgn_x;
        logic [WIDTH-1:0] res;
        logic             ovf;
    } regs_t;

    regs_t q, d;

    logic             sgn_a, sgn_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic [ACC_W-1:0] acc_nx, mcand_nx;
    logic [MAG_W-1:0] mplier_nx;
    logic [MAG_W-1:0] fin_mag;
    logic             fin_sgn, fin_ovf;

    fxm_split #(.WIDTH(WIDTH)) u_split_a (.word(op_a), .sgn(sgn_a), .mag(mag_a));
    fxm_split #(.WIDTH(WIDTH)) u_split_b (.word(op_b), .sgn(sgn_b), .mag(mag_b));

    fxm_step #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_step (
        .acc      (q.acc),
        .mcand    (q.mcand),
        .mplier   (q.mplier),
        .acc_nx   (acc_nx),
        .mcand_nx (mcand_nx),
        .mplier_nx(mplier_nx)
    );

    fxm_realign #(.FRAC_W(FRAC_W), .MAG_W(MAG_W), .ACC_W(ACC_W)) u_realign (
        .acc   (acc_nx),
        .sgn_in(q.sgn_x),
        .mag   (fin_mag),
        .sgn   (fin_sgn),
        .ovf   (fin_ovf)
    );

    always_comb begin
        d = q;
        case (q.st)
            FXM_IDLE, FXM_DONE: begin
                if (start) begin
                    d.st     = FXM_RUN;
                    d.cnt    = '0;
                    d.acc    = '0;
                    d.mcand  = ACC_W'(mag_a);
                    d.mplier = mag_b;
                    d.sgn_x  = sgn_a ^ sgn_b;
                end
            end
            FXM_RUN: begin
                d.acc    = acc_nx;
                d.mcand  = mcand_nx;
                d.mplier = mplier_nx;
                d.cnt    = q.cnt + CNT_W'(1);
                if (q.cnt == LAST) begin
                    d.st  = FXM_DONE;
                    d.res = {fin_sgn, fin_mag};
                    d.ovf = fin_ovf;
                end
            end
            default: d.st = FXM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FXM_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign result = q.res;
    assign done   = (q.st == FXM_DONE);
    assign ovf    = q.ovf;

    logic busy;
    assign busy = (q.st == FXM_RUN);

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && q.cnt == '0 && q.acc == '0));

    assert_busy_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.cnt != LAST) |=> (busy && q.cnt == $past(q.cnt) + CNT_W'(1)));

    assert_no_done_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && $past(q.cnt) == LAST));

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result) && $stable(ovf)));

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && busy));

    assert_zero_positive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[WIDTH-2:0] == '0) |-> !result[WIDTH-1]);
endmodule

// File: tb/sim_fxm_seq_mult.sv
module sim_fxm_seq_mult;
    localparam int Q = 15;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic [N-1:0] result;
    logic         done;
    logic         ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fxm_seq_mult #(.FRAC_W(Q), .WIDTH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b),
        .result(result), .done(done), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model(input logic [N-1:0] a, input logic [N-1:0] b,
                         output logic [N-1:0] r, output logic o);
        longint unsigned full, sh;
        logic [N-2:0] m;
        full = longint'(a[N-2:0]) * longint'(b[N-2:0]);
        sh   = full >> Q;
        m    = sh[N-2:0];
        o    = (sh >> (N-1)) != 0;
        r    = {(a[N-1] ^ b[N-1]) & (m != 0), m};
    endtask

    task automatic launch(input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        repeat (N-2) @(negedge clk);
        chk(done == 1'b0, {tag, " R5 done early"}, 64'(done), 64'd0);
        @(negedge clk);
        chk(done == 1'b1, {tag, " R5 done late"}, 64'(done), 64'd1);
    endtask

    task automatic run_check(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
        logic [N-1:0] er;
        logic eo;
        model(a, b, er, eo);
        launch(a, b);
        wait_done(tag);
        chk(result == er, {tag, " result"}, 64'(result), 64'(er));
        chk(ovf == eo, {tag, " R3 ovf"}, 64'(ovf), 64'(eo));
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(ovf == 1'b0, "R1 ovf", 64'(ovf), 64'd0);
        chk(result == '0, "R1 result", 64'(result), 64'd0);
    endtask

    task automatic t_basic;
        run_check(32'h0000_8000, 32'h0000_8000, "R2 one*one");
        run_check(32'h0001_4000, 32'h8000_C000, "R2 R4 2.5*-1.5");
        run_check(32'h8000_4000, 32'h8000_2000, "R2 R4 neg*neg");
        run_check(32'h0000_0003, 32'h0000_4000, "R2 truncate");
        run_check(32'h0123_4567, 32'h8002_9ABC, "R2 mixed");
    endtask

    task automatic t_overflow;
        run_check(32'h7FFF_FFFF, 32'h0001_0000, "R3 over");
        run_check(32'h7FFF_FFFF, 32'h0000_8000, "R3 max no over");
        run_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R4 both max neg");
    endtask

    task automatic t_zero_sign;
        run_check(32'h8000_0000, 32'h0000_8000, "R4 negzero");
        run_check(32'h8000_0001, 32'h0000_0001, "R4 trunc to zero");
    endtask

    task automatic t_hold;
        logic [N-1:0] er;
        logic eo;
        model(32'h0000_C000, 32'h8000_A000, er, eo);
        launch(32'h0000_C000, 32'h8000_A000);
        wait_done("R6 hold");
        op_a = 32'h1234_5678;
        op_b = 32'h0BAD_0BAD;
        repeat (6) @(negedge clk);
        chk(done == 1'b1, "R6 done held", 64'(done), 64'd1);
        chk(result == er, "R6 result held", 64'(result), 64'(er));
        launch(32'h0000_8000, 32'h0000_8000);
        chk(done == 1'b0, "R6 restart clears done", 64'(done), 64'd0);
        wait_done("R6 restart");
        chk(result == 32'h0000_8000, "R6 restart result", 64'(result), 64'h8000);
    endtask

    task automatic t_busy_start;
        logic [N-1:0] er;
        logic eo;
        model(32'h0003_0000, 32'h0000_6000, er, eo);
        launch(32'h0003_0000, 32'h0000_6000);
        repeat (5) @(negedge clk);
        op_a  = 32'h7FFF_FFFF;
        op_b  = 32'h7FFF_FFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N-2-6) @(negedge clk);
        chk(done == 1'b0, "R7 timing early", 64'(done), 64'd0);
        @(negedge clk);
        chk(done == 1'b1, "R7 timing on time", 64'(done), 64'd1);
        chk(result == er, "R7 result kept", 64'(result), 64'(er));
        chk(ovf == eo, "R7 ovf kept", 64'(ovf), 64'(eo));
    endtask

    task automatic t_operand_change;
        logic [N-1:0] er;
        logic eo;
        model(32'h8000_9000, 32'h0002_2000, er, eo);
        launch(32'h8000_9000, 32'h0002_2000);
        op_a = 32'h0000_0001;
        op_b = 32'h0000_0000;
        wait_done("R8 change");
        chk(result == er, "R8 captured operands", 64'(result), 64'(er));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_overflow();
        t_zero_sign();
        t_hold();
        t_busy_start();
        t_operand_change();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule